// File: doc/BRIEF.md
# Serial Port Core with Transmit Queue and Interrupts

This block is a memory-mapped asynchronous serial port. A 32-bit register port lets software set a 16-bit baud increment, enable the transmitter and the receiver, queue bytes for transmission and read the last received byte. Frames use 8N1 format, least significant bit first: one start bit, eight data bits and one stop bit, so each character is ten bit times long.

Bit timing comes from a phase accumulator. Every clock it adds the baud increment, and each carry out is one oversample tick. A bit lasts 16 ticks, which gives baud = increment × f_clk / 2^20. Transmit bytes wait in a 16-entry queue. The receiver keeps one holding byte. Four level interrupts report transmit-threshold, receive-threshold, transmit-drained and receive-overrun events. Each has its own enable bit.

The register words are found at these byte offsets:

- 0x00: interrupt state
- 0x04: interrupt enable
- 0x08: interrupt test
- 0x0C: control
- 0x10: status
- 0x14: receive byte
- 0x18: transmit byte
- 0x1C: queue control
- 0x20: queue level
- 0x24: spare override word
- 0x28: spare value word
- 0x2C: spare timeout word

Top module: `serial_port_core`

## Requirements
- R1: After reset, status reads 0x34 (bit 2 transmit-empty, bit 4 receive-idle, bit 5 receive-empty), all interrupt outputs are low and the serial output is high.
- R2: Interrupt output bit k is high while interrupt state bit k and enable bit k are both set. The bit assignments are: bit 0 transmit threshold, bit 1 receive threshold, bit 2 transmit drained, bit 3 receive overrun.
- R3: A write to the interrupt state word clears every bit written as 1. A write to the interrupt test word sets every bit written as 1. The test word always reads zero.
- R4: With increment 0x8000 each bit lasts 32 clocks. The transmitted frame is a low start bit, then eight data bits LSB first, then a high stop bit, and queued bytes leave in write order.
- R5: Control bit 0 enables transmission. While it is clear, no frame starts and the serial output stays high.
- R6: The transmit queue holds 16 bytes. A write while the queue is full is dropped. Status bit 0 is set exactly at 16 entries. The queue-level word reports the fill count in bits 4:0.
- R7: Writing 1 to queue-control bit 1 empties the transmit queue, and the queued bytes are never sent.
- R8: Queue-control bits 6:5 give the transmit threshold. Interrupt state bit 0 is set when a write brings the fill count to or above the threshold. It is cleared when a dequeue brings the count below the threshold.
- R9: When the queue drains to zero, status bit 2 and interrupt state bit 2 are set.
- R10: With control bit 1 set, a received byte is placed in the receive word and clears status bits 4 and 5 (bit 1 goes high). Reading the receive word sets bits 4 and 5 again. Interrupt state bit 1 is set on arrival when one unread byte exceeds the receive threshold in queue-control bits 4:2.
- R11: A byte that arrives while the previous one is still unread sets interrupt state bit 3 and replaces the held byte.
- R12: With control bit 1 clear, incoming frames are ignored. The spare override and timeout words read back what was written, and they have no effect on the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| irq_o | output | 4 | Level interrupts, bit order as in R2 |

## Verification
The hardest condition to reach is the threshold-crossing interrupt on the way down: the transmit-threshold bit clears only when a dequeue drops the count below the threshold. That dequeue happens in the middle of a serial frame and cannot be triggered directly from the register port. The stimulus fills the queue to capacity with the transmitter disabled, which also tests the dropped seventeenth write, and leaves the threshold bit set. It then enables transmission and lets the whole queue drain while a serial monitor checks every frame against the expected bytes. At the end the state word must show the drained bit set and the threshold bit cleared by hardware.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

   // word index of each register (byte address bits 5:2)
   typedef enum logic [3:0] {
      RG_IRQ_STATE = 4'd0,
      RG_IRQ_EN    = 4'd1,
      RG_IRQ_TEST  = 4'd2,
      RG_CONTROL   = 4'd3,
      RG_STATUS    = 4'd4,
      RG_RX_BYTE   = 4'd5,
      RG_TX_BYTE   = 4'd6,
      RG_Q_CTRL    = 4'd7,
      RG_Q_LEVEL   = 4'd8,
      RG_SPARE_OVR = 4'd9,
      RG_SPARE_VAL = 4'd10,
      RG_SPARE_TMO = 4'd11
   } reg_word_e;

   // interrupt bit positions
   localparam int IB_TX_MARK  = 0;
   localparam int IB_RX_MARK  = 1;
   localparam int IB_TX_DRAIN = 2;
   localparam int IB_RX_OVR   = 3;
   localparam int IRQ_N       = 4;

   localparam int BYTE_W      = 8;
   localparam int FRAME_BITS  = 10;

endpackage

// File: rtl/sp_baud_nco.sv
module sp_baud_nco #(
   parameter int INC_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [INC_W-1:0] inc_i,
   output logic             tick_o
);
   logic [INC_W-1:0] phase_q;
   logic [INC_W:0]   sum;

   assign sum = {1'b0, phase_q} + {1'b0, inc_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= '0;
         tick_o  <= 1'b0;
      end else begin
         phase_q <= sum[INC_W-1:0];
         tick_o  <= sum[INC_W];
      end
   end
endmodule

// File: rtl/sp_tx_queue.sv
module sp_tx_queue #(
   parameter int DEPTH  = 16,
   parameter int DW     = 8,
   localparam int PW    = $clog2(DEPTH),
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          push_i,
   input  logic [DW-1:0] data_i,
   input  logic          pop_i,
   input  logic          flush_i,
   output logic [DW-1:0] data_o,
   output logic [LW-1:0] level_o,
   output logic          full_o,
   output logic          empty_o
);
   logic [DW-1:0] store_q [DEPTH];
   logic [PW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full_o  = (level_o == LW'(DEPTH));
   assign empty_o = (level_o == '0);
   assign do_push = push_i && !full_o && !flush_i;
   assign do_pop  = pop_i && !empty_o && !flush_i;
   assign data_o  = store_q[rd_q];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_q + PW'(1);
         assign rd_nxt = rd_q + PW'(1);
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
         assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (do_push) store_q[wr_q] <= data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_q    <= '0;
         rd_q    <= '0;
         level_o <= '0;
      end else if (flush_i) begin
         wr_q    <= '0;
         rd_q    <= '0;
         level_o <= '0;
      end else begin
         if (do_push) wr_q <= wr_nxt;
         if (do_pop)  rd_q <= rd_nxt;
         if (do_push && !do_pop)      level_o <= level_o + LW'(1);
         else if (do_pop && !do_push) level_o <= level_o - LW'(1);
      end
   end
endmodule

// File: rtl/sp_tx_shift.sv
module sp_tx_shift
   import serial_port_pkg::*;
#(
   parameter int OVS = 16,
   localparam int TW = $clog2(OVS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              enable_i,
   input  logic              avail_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              take_o,
   output logic              busy_o,
   output logic              txd_o
);
   logic [FRAME_BITS-1:0] frame_q;
   logic [3:0]            bit_q;
   logic [TW-1:0]         tick_q;

   assign take_o = !busy_o && enable_i && avail_i;
   assign txd_o  = busy_o ? frame_q[0] : 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o  <= 1'b0;
         frame_q <= '1;
         bit_q   <= '0;
         tick_q  <= '0;
      end else if (!busy_o) begin
         if (take_o) begin
            busy_o  <= 1'b1;
            frame_q <= {1'b1, data_i, 1'b0};
            bit_q   <= '0;
            tick_q  <= '0;
         end
      end else if (tick_i) begin
         if (tick_q == TW'(OVS - 1)) begin
            tick_q <= '0;
            if (bit_q == 4'(FRAME_BITS - 1)) begin
               busy_o <= 1'b0;
            end else begin
               bit_q   <= bit_q + 4'd1;
               frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
            end
         end else begin
            tick_q <= tick_q + TW'(1);
         end
      end
   end
endmodule

// File: rtl/sp_rx_shift.sv
module sp_rx_shift
   import serial_port_pkg::*;
#(
   parameter int OVS  = 16,
   localparam int TW  = $clog2(OVS),
   localparam int MID = OVS / 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              enable_i,
   input  logic              rxd_i,
   output logic              valid_o,
   output logic [BYTE_W-1:0] data_o
);
   logic          s1_q, s2_q, s3_q;
   logic          busy_q;
   logic [3:0]    bit_q;
   logic [TW-1:0] tick_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_q    <= 1'b1;
         s2_q    <= 1'b1;
         s3_q    <= 1'b1;
         busy_q  <= 1'b0;
         bit_q   <= '0;
         tick_q  <= '0;
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         s1_q    <= rxd_i;
         s2_q    <= s1_q;
         s3_q    <= s2_q;
         valid_o <= 1'b0;
         if (!busy_q) begin
            if (enable_i && s3_q && !s2_q) begin
               busy_q <= 1'b1;
               bit_q  <= '0;
               tick_q <= '0;
            end
         end else if (tick_i) begin
            if (tick_q == TW'(OVS - 1)) begin
               tick_q <= '0;
               bit_q  <= bit_q + 4'd1;
            end else begin
               tick_q <= tick_q + TW'(1);
            end
            if (tick_q == TW'(MID - 1)) begin
               if (bit_q == 4'd0) begin
                  if (s2_q) busy_q <= 1'b0;
               end else if (bit_q == 4'(FRAME_BITS - 1)) begin
                  busy_q  <= 1'b0;
                  valid_o <= s2_q;
               end else begin
                  data_o <= {s2_q, data_o[BYTE_W-1:1]};
               end
            end
         end
      end
   end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
   import serial_port_pkg::*;
#(
   parameter int Q_DEPTH = 16,
   parameter int INC_W   = 16,
   parameter int OVS     = 16,
   localparam int LW     = $clog2(Q_DEPTH + 1)
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        req_i,
   input  logic        we_i,
   input  logic [5:0]  addr_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rdata_o,
   output logic        txd_o,
   input  logic        rxd_i,
   output logic [3:0]  irq_o
);
   generate
      if (Q_DEPTH < 2 || Q_DEPTH > 31) begin : g_bad_depth
         $error("Q_DEPTH must lie in 2..31 to fit the level field");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (INC_W < 2 || INC_W > 16) begin : g_bad_inc
         $error("INC_W must lie in 2..16");
      end
   endgenerate

   logic [IRQ_N-1:0] ist_q, ien_q, hw_set, hw_clr;
   logic [31:0]      ctl_q, ovr_q, tmo_q;
   logic [4:0]       qctl_q;
   logic [BYTE_W-1:0] rxb_q;
   logic             unread_q;

   logic             wr, rd;
   logic [3:0]       widx;
   logic             q_push, q_flush, q_pop, q_full, q_empty, tx_busy;
   logic [LW-1:0]    q_level;
   logic [LW:0]      lvl_after;
   logic [BYTE_W-1:0] q_data, rx_data;
   logic             tick, rx_valid, rd_rxb;
   logic [1:0]       tx_thr;
   logic [2:0]       rx_thr;

   assign wr      = req_i && we_i;
   assign rd      = req_i && !we_i;
   assign widx    = addr_i[5:2];
   assign q_push  = wr && (widx == RG_TX_BYTE);
   assign q_flush = wr && (widx == RG_Q_CTRL) && wdata_i[1];
   assign rd_rxb  = rd && (widx == RG_RX_BYTE);
   assign tx_thr  = qctl_q[4:3];
   assign rx_thr  = qctl_q[2:0];

   sp_baud_nco #(.INC_W(INC_W)) u_nco (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .inc_i (ctl_q[16 +: INC_W]), .tick_o(tick)
   );

   sp_tx_queue #(.DEPTH(Q_DEPTH), .DW(BYTE_W)) u_queue (
      .clk_i  (clk_i), .rst_ni(rst_ni),
      .push_i (q_push), .data_i(wdata_i[BYTE_W-1:0]),
      .pop_i  (q_pop), .flush_i(q_flush),
      .data_o (q_data), .level_o(q_level),
      .full_o (q_full), .empty_o(q_empty)
   );

   sp_tx_shift #(.OVS(OVS)) u_tx (
      .clk_i   (clk_i), .rst_ni(rst_ni), .tick_i(tick),
      .enable_i(ctl_q[0]), .avail_i(!q_empty && !q_flush),
      .data_i  (q_data), .take_o(q_pop), .busy_o(tx_busy),
      .txd_o   (txd_o)
   );

   sp_rx_shift #(.OVS(OVS)) u_rx (
      .clk_i   (clk_i), .rst_ni(rst_ni), .tick_i(tick),
      .enable_i(ctl_q[1]), .rxd_i(rxd_i),
      .valid_o (rx_valid), .data_o(rx_data)
   );

   // fill count after this cycle's push and pop
   always_comb begin
      lvl_after = {1'b0, q_level};
      if (q_push && !q_full) lvl_after = lvl_after + (LW+1)'(1);
      if (q_pop)             lvl_after = lvl_after - (LW+1)'(1);
   end

   always_comb begin
      hw_set = '0;
      hw_clr = '0;
      if (q_push && !q_full && lvl_after >= (LW+1)'(tx_thr)) hw_set[IB_TX_MARK] = 1'b1;
      if (q_pop && lvl_after < (LW+1)'(tx_thr))              hw_clr[IB_TX_MARK] = 1'b1;
      if (q_flush && tx_thr != 2'd0)                         hw_clr[IB_TX_MARK] = 1'b1;
      if (q_pop && lvl_after == '0)                          hw_set[IB_TX_DRAIN] = 1'b1;
      if (rx_valid && rx_thr == 3'd0)                        hw_set[IB_RX_MARK] = 1'b1;
      if (rx_valid && unread_q && !rd_rxb)                   hw_set[IB_RX_OVR] = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ist_q    <= '0;
         ien_q    <= '0;
         ctl_q    <= '0;
         qctl_q   <= '0;
         ovr_q    <= '0;
         tmo_q    <= '0;
         rxb_q    <= '0;
         unread_q <= 1'b0;
      end else begin
         begin : upd_state
            logic [IRQ_N-1:0] nxt;
            nxt = (ist_q & ~hw_clr) | hw_set;
            if (wr && widx == RG_IRQ_STATE) nxt = nxt & ~wdata_i[IRQ_N-1:0];
            if (wr && widx == RG_IRQ_TEST)  nxt = nxt | wdata_i[IRQ_N-1:0];
            ist_q <= nxt;
         end
         if (wr && widx == RG_IRQ_EN)    ien_q  <= wdata_i[IRQ_N-1:0];
         if (wr && widx == RG_CONTROL)   ctl_q  <= wdata_i;
         if (wr && widx == RG_Q_CTRL)    qctl_q <= wdata_i[6:2];
         if (wr && widx == RG_SPARE_OVR) ovr_q  <= wdata_i;
         if (wr && widx == RG_SPARE_TMO) tmo_q  <= wdata_i;
         if (rx_valid) begin
            rxb_q    <= rx_data;
            unread_q <= 1'b1;
         end else if (rd_rxb) begin
            unread_q <= 1'b0;
         end
      end
   end

   assign irq_o = ist_q & ien_q;

   always_comb begin
      rdata_o = '0;
      if (rd) begin
         case (widx)
            RG_IRQ_STATE: rdata_o = 32'(ist_q);
            RG_IRQ_EN:    rdata_o = 32'(ien_q);
            RG_CONTROL:   rdata_o = ctl_q;
            RG_STATUS:    rdata_o = {26'd0, !unread_q, !unread_q, 1'b0,
                                     q_empty, unread_q, q_full};
            RG_RX_BYTE:   rdata_o = 32'(rxb_q);
            RG_Q_CTRL:    rdata_o = {25'd0, qctl_q, 2'b00};
            RG_Q_LEVEL:   rdata_o = 32'(q_level);
            RG_SPARE_OVR: rdata_o = ovr_q;
            RG_SPARE_TMO: rdata_o = tmo_q;
            default:      rdata_o = '0;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{addr_i[1:0], ctl_q, tx_busy};
endmodule

// File: rtl/serial_port_core_chk.sv
module serial_port_core_chk #(
   parameter int Q_DEPTH = 16,
   localparam int LW     = $clog2(Q_DEPTH + 1)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          req_i,
   input logic          we_i,
   input logic [5:0]    addr_i,
   input logic [31:0]   wdata_i,
   input logic          txd_o,
   input logic [3:0]    ist,
   input logic [LW-1:0] level,
   input logic          pop,
   input logic          flush,
   input logic          tx_busy
);
   logic wr_state, wr_test;
   assign wr_state = req_i && we_i && addr_i[5:2] == 4'd0;
   assign wr_test  = req_i && we_i && addr_i[5:2] == 4'd2;

   p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_state && wdata_i[3]) |=> !ist[3]);

   p_test_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_test && wdata_i[0]) |=> ist[0]);

   p_level_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level <= LW'(Q_DEPTH));

   p_full_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level == LW'(Q_DEPTH) && !pop && !flush) |=> level == LW'(Q_DEPTH));

   p_flush_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush |=> level == '0);

   p_idle_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tx_busy |-> txd_o);
endmodule

bind serial_port_core serial_port_core_chk #(.Q_DEPTH(Q_DEPTH)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .req_i  (req_i),
   .we_i   (we_i),
   .addr_i (addr_i),
   .wdata_i(wdata_i),
   .txd_o  (txd_o),
   .ist    (ist_q),
   .level  (q_level),
   .pop    (q_pop),
   .flush  (q_flush),
   .tx_busy(tx_busy)
);

// File: tb/serial_port_core_tb_top.sv
module serial_port_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        txd;
   logic        rx_drv = 1'b1;
   logic [3:0]  irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [7:0] exp_q [$];

   localparam logic [5:0] A_IST = 6'h00, A_IEN = 6'h04, A_ITST = 6'h08,
      A_CTL = 6'h0C, A_STS = 6'h10, A_RXB = 6'h14, A_TXB = 6'h18,
      A_QCTL = 6'h1C, A_QLVL = 6'h20, A_OVR = 6'h24;
   localparam logic [31:0] INC = 32'h8000_0000;  // increment 0x8000 -> 32 clocks/bit

   always #2 clk = ~clk;

   serial_port_core dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .rxd_i(rx_drv),
      .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk); req = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk); req = 1'b0;
   endtask

   // driver: queue a byte and, if the model says it fits, expect it on the line
   task automatic send_tx(input logic [7:0] b, input bit expect_it);
      wr(A_TXB, {24'd0, b});
      if (expect_it) exp_q.push_back(b);
   endtask

   task automatic send_rx(input logic [7:0] b);
      @(negedge clk); rx_drv = 1'b0;
      repeat (32) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_drv = b[i];
         repeat (32) @(negedge clk);
      end
      rx_drv = 1'b1;
      repeat (40) @(negedge clk);
   endtask

   // monitor: decode frames on the serial output and compare with the queue
   initial begin
      forever begin
         logic [7:0] got;
         @(negedge txd);
         repeat (16) @(negedge clk);
         chk("R4 start bit", 32'(txd), 32'd0);
         for (int i = 0; i < 8; i++) begin
            repeat (32) @(negedge clk);
            got[i] = txd;
         end
         repeat (32) @(negedge clk);
         chk("R4 stop bit", 32'(txd), 32'd1);
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4/R7 unexpected frame: actual=0x%0h expected=none", got);
         end else begin
            chk("R4 frame byte", 32'(got), 32'(exp_q.pop_front()));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int lowlen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_STS, v); chk("R1 status", v, 32'h34);
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 line", 32'(txd), 32'd1);

      // R2/R3 enable gating, test set, write-one-to-clear
      wr(A_IEN, 32'hF); wr(A_ITST, 32'hF);
      chk("R2 irq all", 32'(irq), 32'hF);
      rd(A_IST, v); chk("R3 test sets", v, 32'hF);
      rd(A_ITST, v); chk("R3 test reads zero", v, 32'h0);
      wr(A_IST, 32'h5);
      rd(A_IST, v); chk("R3 w1c", v, 32'hA);
      wr(A_IEN, 32'h2);
      chk("R2 gating", 32'(irq), 32'h2);
      wr(A_IST, 32'hF);
      rd(A_IST, v); chk("R3 clear all", v, 32'h0);
      wr(A_IEN, 32'hF);

      // R5/R6/R8 fill with transmitter disabled, threshold 3
      wr(A_CTL, INC);
      wr(A_QCTL, 32'h60);
      send_tx(8'h10, 1); send_tx(8'h21, 1);
      rd(A_IST, v); chk("R8 below threshold", v & 32'h1, 32'h0);
      send_tx(8'h32, 1);
      rd(A_IST, v); chk("R8 at threshold", v & 32'h1, 32'h1);
      for (int i = 3; i < 16; i++) send_tx(8'(8'hC0 + i), 1);
      send_tx(8'hEE, 0);  // 17th write must be dropped
      rd(A_QLVL, v); chk("R6 level full", v & 32'h1F, 32'd16);
      rd(A_STS, v); chk("R6 full flag", v & 32'h5, 32'h1);
      repeat (200) @(negedge clk);
      chk("R5 line idle while disabled", 32'(txd), 32'd1);
      rd(A_QLVL, v); chk("R5 nothing sent", v, 32'd16);

      // R9/R8 drain
      wr(A_CTL, INC | 32'h1);
      repeat (16 * 320 + 300) @(negedge clk);
      chk("R4 all frames seen", 32'(exp_q.size()), 32'd0);
      rd(A_QLVL, v); chk("R9 level zero", v, 32'd0);
      rd(A_STS, v); chk("R9 empty status", v & 32'h5, 32'h4);
      rd(A_IST, v); chk("R9 drain irq", v & 32'h4, 32'h4);
      chk("R8 mark cleared on drain", v & 32'h1, 32'h0);

      // R7 flush
      wr(A_CTL, INC);
      for (int i = 0; i < 5; i++) send_tx(8'(8'h70 + i), 0);
      rd(A_QLVL, v); chk("R7 level before", v, 32'd5);
      wr(A_QCTL, 32'h62);
      rd(A_QLVL, v); chk("R7 flushed", v, 32'd0);
      wr(A_CTL, INC | 32'h1);
      repeat (400) @(negedge clk);
      chk("R7 line idle", 32'(txd), 32'd1);

      // R4 bit period: 0x00 gives 9 low bit times
      send_tx(8'h00, 1);
      @(negedge txd);
      lowlen = 0;
      while (txd == 1'b0) begin @(negedge clk); lowlen++; end
      chk("R4 low run 286..290", 32'(lowlen >= 286 && lowlen <= 290), 32'd1);
      send_tx(8'hFF, 1); send_tx(8'h5A, 1);
      repeat (1000) @(negedge clk);
      chk("R4 burst seen", 32'(exp_q.size()), 32'd0);

      // R10 receive
      wr(A_CTL, INC | 32'h3);
      wr(A_QCTL, 32'h60);
      wr(A_IST, 32'hF);
      send_rx(8'hA5);
      rd(A_STS, v); chk("R10 status after rx", v & 32'h32, 32'h02);
      rd(A_IST, v); chk("R10 rx mark", v & 32'hA, 32'h2);
      rd(A_RXB, v); chk("R10 data", v, 32'hA5);
      rd(A_STS, v); chk("R10 status after read", v & 32'h32, 32'h30);

      // R11 overrun
      wr(A_IST, 32'hF);
      send_rx(8'h11);
      rd(A_IST, v); chk("R11 no overrun yet", v & 32'h8, 32'h0);
      send_rx(8'h22);
      rd(A_IST, v); chk("R11 overrun", v & 32'h8, 32'h8);
      chk("R11 irq out", 32'(irq[3]), 32'd1);
      rd(A_RXB, v); chk("R11 newest kept", v, 32'h22);

      // R10 threshold above one unread byte
      wr(A_QCTL, 32'h64);
      wr(A_IST, 32'hF);
      send_rx(8'h33);
      rd(A_IST, v); chk("R10 thr 1 no mark", v & 32'h2, 32'h0);
      rd(A_RXB, v); chk("R10 data 2", v, 32'h33);

      // R12 receiver disabled, spare words
      wr(A_CTL, INC | 32'h1);
      send_rx(8'h44);
      rd(A_STS, v); chk("R12 rx ignored", v & 32'h20, 32'h20);
      wr(A_OVR, 32'h0000_1234);
      rd(A_OVR, v); chk("R12 spare readback", v, 32'h1234);
      repeat (50) @(negedge clk);
      chk("R12 line unaffected", 32'(txd), 32'd1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule